// File: doc/BRIEF.md
# Three-Phase Interleaved Vertical Link Controller

This block sequences one die's share of a vertical serial link that several stacked dies reach through the same location. Only one die may drive the link at a time. A slow system tick restarts a fixed rotation of three phases. In phase p, the die whose chip number equals p transmits. The die numbered p+1 receives both clock and data. Every other die receives only the clock, so that it can follow the phase count. The 2-bit chip number sets the role of each phase, and the roles are latched again on every system tick.

While transmitting, the block shifts a held word out on a data line, most significant bit first, next to a strobe that marks each bit. While receiving, it shifts in one bit for every received strobe and reports the word when the last bit arrives. The word is 26 bits wide by default: 24 data bits plus 2 carry bits. The word is opaque to the block.

A phase is made of two segments. The bit segment ends once the word's bit count is reached. A transmitter counts its own local clocks, and a receiver counts received strobes. A gap of GAP_CLKS local clocks follows, with every driver and receiver disabled, to absorb skew between dies. The outbound word arrives over a valid/ready handshake. A word is accepted when tx_valid and tx_ready are both high in the same cycle. tx_ready stays low while a word waits, and the producer holds tx_valid and tx_word until it is accepted. The inbound word has no back-pressure: rx_valid is high for one cycle, and the consumer must take rx_word in that cycle. WORD_W must be at least 2 and GAP_CLKS at least 1.

Top module: `tpi_link_pcu`

## Requirements
- R1: After reset, tx_en, rxd_en, rxc_en, tx_strobe and rx_valid are low and tx_ready is high.
- R2: During the bit segment of phase p, exactly one enable is high. tx_en is high when chip_id equals p, rxd_en is high when chip_id equals p+1, and rxc_en is high otherwise. Outside bit segments all three are low.
- R3: A transmitting die that holds a word drives tx_strobe high for WORD_W consecutive cycles, starting the cycle after the phase begins. tx_data carries the word most significant bit first, one bit per strobe cycle.
- R4: A die in the receive-data role shifts rx_data in on each rx_strobe cycle, with the first bit ending up in the top position. One cycle after the WORD_W-th strobe is captured, rx_valid is high for exactly one cycle with the word on rx_word. A die in the clock-only role never raises rx_valid.
- R5: After a bit segment ends, every enable stays low for exactly GAP_CLKS cycles. Then the next phase begins. With the defaults and a continuous strobe, phases 1 and 2 start 30 and 60 cycles after phase 0.
- R6: A sys_tick pulse, sampled at any point in the sequence, restarts the sequence at the bit segment of phase 0 and relatches the roles from chip_id.
- R7: A word is accepted when tx_valid and tx_ready are both high. tx_ready then stays low, and later words are refused, until the die's next transmit phase begins. tx_ready is high again in the first cycle of that phase.
- R8: A transmitting die with no held word drives no strobes, yet still leaves its bit segment after WORD_W local clocks. Receivers of that phase stay in their bit segment until the next sys_tick.
- R9: After the gap that follows phase 2, all enables stay low until the next sys_tick.
- R10: A receiver counts only cycles in which rx_strobe is high, so strobes spread over non-adjacent cycles still assemble the correct word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast local clock |
| rst | input | 1 | Synchronous reset, active high |
| sys_tick | input | 1 | One-cycle pulse that restarts the phase rotation |
| chip_id | input | CHIP_W | Position of this die in the stack |
| tx_valid | input | 1 | Outbound word is offered |
| tx_ready | output | 1 | Holding register is empty |
| tx_word | input | WORD_W | Outbound word |
| tx_strobe | output | 1 | Forwarded bit clock, one pulse per bit |
| tx_data | output | 1 | Serial data bit, valid while tx_strobe is high |
| rx_strobe | input | 1 | Received bit clock |
| rx_data | input | 1 | Received serial data bit |
| rx_valid | output | 1 | One-cycle flag: rx_word holds a complete word |
| rx_word | output | WORD_W | Assembled inbound word |
| tx_en | output | 1 | Transmitter activation for the current phase |
| rxd_en | output | 1 | Clock and data receiver activation |
| rxc_en | output | 1 | Clock-only receiver activation |

## Verification
The bench builds four copies of the block with the default parameters: a 26-bit word, a 4-clock gap and 2-bit chip numbers. The copies carry chip numbers 0 to 3 and share a single wired link. Every die therefore takes every role it can hold in the rotation, and each bit segment and gap can be timed from one sys_tick. A full-length word with both the top and bottom bits set exposes errors in bit order and bit count. A bench-driven override of the shared line reaches receivers with strobes that arrive every other cycle. Runs with no pending word, and a restart issued in the middle of phase 1, cover the stall and restart paths.

// File: rtl/tpi_pkg.sv
package tpi_pkg;

  typedef enum logic [1:0] {
    ROLE_RXC = 2'd0,
    ROLE_TX  = 2'd1,
    ROLE_RXD = 2'd2
  } role_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BITS = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_e;

  // Role of a die in one phase: sender is chip p, target is chip p+1.
  function automatic role_e role_of(input int unsigned chip, input int unsigned phase);
    if (chip == phase)          return ROLE_TX;
    else if (chip == phase + 1) return ROLE_RXD;
    else                        return ROLE_RXC;
  endfunction

endpackage

// File: rtl/tpi_role_file.sv
module tpi_role_file
  import tpi_pkg::*;
#(
  parameter int CHIP_W = 2,
  parameter int NPHASE = 3,
  parameter int PH_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CHIP_W-1:0] chip_id,
  input  logic [PH_W-1:0]   rd_phase,
  input  logic [PH_W-1:0]   start_phase,
  output role_e             cur_role,
  output role_e             start_role
);

  role_e roles [NPHASE];

  // One entry per phase, refreshed on every system tick (R6)
  for (genvar p = 0; p < NPHASE; p++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)       roles[p] <= ROLE_RXC;
      else if (load) roles[p] <= role_of(32'(chip_id), p);
    end
  end

  always_comb begin
    cur_role = ROLE_RXC;
    if (32'(rd_phase) < NPHASE) cur_role = roles[rd_phase];
  end

  // At a tick the table is being rewritten, so phase 0 comes straight from chip_id
  always_comb begin
    if (load) begin
      start_role = role_of(32'(chip_id), 0);
    end else begin
      start_role = ROLE_RXC;
      if (32'(start_phase) < NPHASE) start_role = roles[start_phase];
    end
  end

endmodule

// File: rtl/tpi_phase_seq.sv
module tpi_phase_seq
  import tpi_pkg::*;
#(
  parameter int WORD_W   = 26,
  parameter int GAP_CLKS = 4,
  parameter int NPHASE   = 3,
  parameter int PH_W     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sys_tick,
  input  logic            bit_tick,
  output seq_e            state_o,
  output logic [PH_W-1:0] phase_o,
  output logic            last_bit,
  output logic            seg_start,
  output logic [PH_W-1:0] start_phase
);

  localparam int CNT_MAX = (WORD_W > GAP_CLKS) ? WORD_W : GAP_CLKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CLKS - 1);
  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(NPHASE - 1);

  seq_e             state_q;
  logic [PH_W-1:0]  phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             gap_done;

  assign gap_done    = (state_q == SEQ_GAP) && (cnt_q == GAP_LAST);
  assign last_bit    = (state_q == SEQ_BITS) && bit_tick && (cnt_q == BIT_LAST);
  assign seg_start   = sys_tick || (gap_done && (phase_q != LAST_PH));
  assign start_phase = sys_tick ? '0 : PH_W'(phase_q + 1'b1);
  assign state_o     = state_q;
  assign phase_o     = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      phase_q <= '0;
      cnt_q   <= '0;
    end else if (sys_tick) begin           // R6 restart from any state
      state_q <= SEQ_BITS;
      phase_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_BITS: begin                     // R3 R4 R10 count on bit_tick only
          if (bit_tick) begin
            if (cnt_q == BIT_LAST) begin
              state_q <= SEQ_GAP;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        SEQ_GAP: begin                      // R5 fixed gap of local clocks
          if (gap_done) begin
            cnt_q <= '0;
            if (phase_q == LAST_PH) begin
              state_q <= SEQ_IDLE;          // R9
            end else begin
              state_q <= SEQ_BITS;
              phase_q <= PH_W'(phase_q + 1'b1);
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= SEQ_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/tpi_tx_ser.sv
module tpi_tx_ser #(
  parameter int WORD_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              launch,
  input  logic              in_bits,
  input  logic              last_bit,
  input  logic              abort,
  output logic              tx_strobe,
  output logic              tx_data
);

  logic              full_q;
  logic              sending_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] shreg_q;
  logic              accept;
  logic              take;

  assign tx_ready = !full_q;                 // R7
  assign accept   = tx_valid && !full_q;
  assign take     = launch && full_q;        // R8 nothing to send when empty

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q    <= 1'b0;
      sending_q <= 1'b0;
      hold_q    <= '0;
      shreg_q   <= '0;
    end else if (take) begin
      shreg_q   <= hold_q;
      sending_q <= 1'b1;
      full_q    <= 1'b0;
    end else begin
      if (accept) begin
        hold_q <= tx_word;
        full_q <= 1'b1;
      end
      if (sending_q && (last_bit || abort)) begin
        sending_q <= 1'b0;
      end else if (sending_q && in_bits) begin
        shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};   // R3 MSB first
      end
    end
  end

  assign tx_strobe = sending_q && in_bits;
  assign tx_data   = tx_strobe && shreg_q[WORD_W-1];

endmodule

// File: rtl/tpi_rx_des.sv
module tpi_rx_des #(
  parameter int WORD_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              rx_data,
  input  logic              finish,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word
);

  logic [WORD_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q  <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= finish;                                   // R4 one-cycle flag
      if (capture) shreg_q <= {shreg_q[WORD_W-2:0], rx_data};
      if (finish)  rx_word <= {shreg_q[WORD_W-2:0], rx_data};
    end
  end

endmodule

// File: rtl/tpi_link_pcu.sv
module tpi_link_pcu
  import tpi_pkg::*;
#(
  parameter int WORD_W   = 26,
  parameter int GAP_CLKS = 4,
  parameter int CHIP_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_tick,
  input  logic [CHIP_W-1:0] chip_id,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_strobe,
  output logic              tx_data,
  input  logic              rx_strobe,
  input  logic              rx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word,
  output logic              tx_en,
  output logic              rxd_en,
  output logic              rxc_en
);

  localparam int NPHASE = (1 << CHIP_W) - 1;
  localparam int PH_W   = (NPHASE > 1) ? $clog2(NPHASE) : 1;

  seq_e            seq_state;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] start_phase;
  logic            last_bit;
  logic            seg_start;
  logic            in_bits;
  logic            bit_tick;
  role_e           cur_role;
  role_e           start_role;

  assign in_bits  = (seq_state == SEQ_BITS);
  // Sender paces on its own clock, receivers on the received strobe
  assign bit_tick = in_bits && ((cur_role == ROLE_TX) || rx_strobe);

  tpi_role_file #(
    .CHIP_W (CHIP_W),
    .NPHASE (NPHASE),
    .PH_W   (PH_W)
  ) u_roles (
    .clk         (clk),
    .rst         (rst),
    .load        (sys_tick),
    .chip_id     (chip_id),
    .rd_phase    (phase),
    .start_phase (start_phase),
    .cur_role    (cur_role),
    .start_role  (start_role)
  );

  tpi_phase_seq #(
    .WORD_W   (WORD_W),
    .GAP_CLKS (GAP_CLKS),
    .NPHASE   (NPHASE),
    .PH_W     (PH_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .sys_tick    (sys_tick),
    .bit_tick    (bit_tick),
    .state_o     (seq_state),
    .phase_o     (phase),
    .last_bit    (last_bit),
    .seg_start   (seg_start),
    .start_phase (start_phase)
  );

  tpi_tx_ser #(
    .WORD_W (WORD_W)
  ) u_tx (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_word   (tx_word),
    .launch    (seg_start && (start_role == ROLE_TX)),
    .in_bits   (in_bits),
    .last_bit  (last_bit),
    .abort     (sys_tick),
    .tx_strobe (tx_strobe),
    .tx_data   (tx_data)
  );

  tpi_rx_des #(
    .WORD_W (WORD_W)
  ) u_rx (
    .clk      (clk),
    .rst      (rst),
    .capture  (in_bits && (cur_role != ROLE_TX) && rx_strobe),
    .rx_data  (rx_data),
    .finish   (last_bit && (cur_role == ROLE_RXD)),
    .rx_valid (rx_valid),
    .rx_word  (rx_word)
  );

  // R2 activation per role, only inside a bit segment
  assign tx_en  = in_bits && (cur_role == ROLE_TX);
  assign rxd_en = in_bits && (cur_role == ROLE_RXD);
  assign rxc_en = in_bits && (cur_role == ROLE_RXC);

endmodule

// File: rtl/tpi_link_pcu_chk.sv
module tpi_link_pcu_chk #(
  parameter int CHIP_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sys_tick,
  input logic [CHIP_W-1:0] chip_id,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_strobe,
  input logic              rx_valid,
  input logic              tx_en,
  input logic              rxd_en,
  input logic              rxc_en
);

  AST_ENABLE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_en, rxd_en, rxc_en})); // R2

  AST_STROBE_IN_TX: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |-> tx_en); // R3

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R4

  AST_VALID_FROM_RXD: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(rxd_en)); // R4

  AST_TICK_PHASE0: assert property (@(posedge clk) disable iff (rst)
    sys_tick |=> (tx_en == ($past(chip_id) == '0))); // R6

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready); // R7

endmodule

bind tpi_link_pcu tpi_link_pcu_chk #(.CHIP_W(CHIP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sys_tick  (sys_tick),
  .chip_id   (chip_id),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_strobe (tx_strobe),
  .rx_valid  (rx_valid),
  .tx_en     (tx_en),
  .rxd_en    (rxd_en),
  .rxc_en    (rxc_en)
);

// File: tb/sim_tpi_link_pcu.sv
module sim_tpi_link_pcu;

  localparam int W = 26;
  localparam logic [2:0] EN_TX = 3'b100, EN_RXD = 3'b010, EN_RXC = 3'b001, EN_NONE = 3'b000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_tick = 1'b0;
  logic [3:0] tx_valid = '0;
  logic [3:0][W-1:0] tx_word_v = '0;
  logic [3:0] tx_ready, tx_strobe, tx_data, rx_valid, tx_en, rxd_en, rxc_en;
  logic [3:0][W-1:0] rx_word_v;
  logic inj = 1'b0, inj_strobe = 1'b0, inj_data = 1'b0;
  logic line_strobe, line_data;

  int checks = 0, fails = 0, n = 0;
  bit done = 1'b0;
  int vcnt [4], vn [4], scnt [4], sfirst [4];
  logic [W-1:0] vword [4];
  logic [2:0] enlog [4][128];
  logic rdy0log [128];
  logic d0first;

  always #2 clk = ~clk;

  assign line_strobe = inj ? inj_strobe : |tx_strobe;
  assign line_data   = inj ? inj_data   : |(tx_data & tx_strobe);

  tpi_link_pcu u0 (.clk(clk), .rst(rst), .sys_tick(sys_tick), .chip_id(2'd0),
    .tx_valid(tx_valid[0]), .tx_ready(tx_ready[0]), .tx_word(tx_word_v[0]),
    .tx_strobe(tx_strobe[0]), .tx_data(tx_data[0]), .rx_strobe(line_strobe), .rx_data(line_data),
    .rx_valid(rx_valid[0]), .rx_word(rx_word_v[0]), .tx_en(tx_en[0]), .rxd_en(rxd_en[0]), .rxc_en(rxc_en[0]));
  tpi_link_pcu u1 (.clk(clk), .rst(rst), .sys_tick(sys_tick), .chip_id(2'd1),
    .tx_valid(tx_valid[1]), .tx_ready(tx_ready[1]), .tx_word(tx_word_v[1]),
    .tx_strobe(tx_strobe[1]), .tx_data(tx_data[1]), .rx_strobe(line_strobe), .rx_data(line_data),
    .rx_valid(rx_valid[1]), .rx_word(rx_word_v[1]), .tx_en(tx_en[1]), .rxd_en(rxd_en[1]), .rxc_en(rxc_en[1]));
  tpi_link_pcu u2 (.clk(clk), .rst(rst), .sys_tick(sys_tick), .chip_id(2'd2),
    .tx_valid(tx_valid[2]), .tx_ready(tx_ready[2]), .tx_word(tx_word_v[2]),
    .tx_strobe(tx_strobe[2]), .tx_data(tx_data[2]), .rx_strobe(line_strobe), .rx_data(line_data),
    .rx_valid(rx_valid[2]), .rx_word(rx_word_v[2]), .tx_en(tx_en[2]), .rxd_en(rxd_en[2]), .rxc_en(rxc_en[2]));
  tpi_link_pcu u3 (.clk(clk), .rst(rst), .sys_tick(sys_tick), .chip_id(2'd3),
    .tx_valid(tx_valid[3]), .tx_ready(tx_ready[3]), .tx_word(tx_word_v[3]),
    .tx_strobe(tx_strobe[3]), .tx_data(tx_data[3]), .rx_strobe(line_strobe), .rx_data(line_data),
    .rx_valid(rx_valid[3]), .rx_word(rx_word_v[3]), .tx_en(tx_en[3]), .rxd_en(rxd_en[3]), .rxc_en(rxc_en[3]));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int d = 0; d < 4; d++) begin
      vcnt[d] = 0; vn[d] = 0; scnt[d] = 0; sfirst[d] = 0; vword[d] = '0;
      for (int i = 0; i < 128; i++) enlog[d][i] = 3'bxxx;
    end
    for (int i = 0; i < 128; i++) rdy0log[i] = 1'bx;
    d0first = 1'bx;
  endtask

  task automatic record();
    for (int d = 0; d < 4; d++) begin
      if (n < 128) enlog[d][n] = {tx_en[d], rxd_en[d], rxc_en[d]};
      if (rx_valid[d]) begin vcnt[d]++; vn[d] = n; vword[d] = rx_word_v[d]; end
      if (tx_strobe[d]) begin
        if (scnt[d] == 0) begin
          sfirst[d] = n;
          if (d == 0) d0first = tx_data[0];
        end
        scnt[d]++;
      end
    end
    if (n < 128) rdy0log[n] = tx_ready[0];
  endtask

  // Pulse sys_tick; the negedge after the sampling edge is n = 1
  task automatic launch_round();
    clear_log();
    @(negedge clk) sys_tick = 1'b1;
    @(negedge clk) sys_tick = 1'b0;
    n = 1;
    record();
  endtask

  task automatic observe_to(input int last);
    while (n < last) begin
      @(negedge clk);
      n++;
      record();
    end
  endtask

  task automatic load(input int d, input logic [W-1:0] w);
    @(negedge clk) begin tx_valid[d] = 1'b1; tx_word_v[d] = w; end
    @(negedge clk) tx_valid[d] = 1'b0;
    chk("R7 ready low after accept", 32'(tx_ready[d]), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 enables after reset", 32'({tx_en, rxd_en, rxc_en}), 32'd0);
    chk("R1 tx_ready after reset", 32'(tx_ready), 32'hF);
    chk("R1 rx_valid after reset", 32'(rx_valid), 32'd0);
    chk("R1 tx_strobe after reset", 32'(tx_strobe), 32'd0);
  endtask

  task automatic t_full_round();
    logic [W-1:0] wa = 26'h2ABCDE1, wb = 26'h1234567, wc = 26'h3C0FFEE;
    load(0, wa); load(1, wb); load(2, wc);
    launch_round();
    observe_to(100);
    chk("R2 u0 phase0 role", 32'(enlog[0][1]), 32'(EN_TX));
    chk("R2 u1 phase0 role", 32'(enlog[1][1]), 32'(EN_RXD));
    chk("R2 u3 phase0 role", 32'(enlog[3][1]), 32'(EN_RXC));
    chk("R2 u0 phase1 role", 32'(enlog[0][31]), 32'(EN_RXC));
    chk("R2 u3 phase2 role", 32'(enlog[3][61]), 32'(EN_RXD));
    chk("R3 u0 strobe count", 32'(scnt[0]), 32'd26);
    chk("R3 u0 first strobe", 32'(sfirst[0]), 32'd1);
    chk("R3 u0 first bit is MSB", 32'(d0first), 32'(wa[W-1]));
    chk("R4 u1 valid count", 32'(vcnt[1]), 32'd1);
    chk("R4 u1 valid cycle", 32'(vn[1]), 32'd27);
    chk("R4 u1 word", 32'(vword[1]), 32'(wa));
    chk("R4 u2 word", 32'(vword[2]), 32'(wb));
    chk("R4 u2 valid cycle", 32'(vn[2]), 32'd57);
    chk("R4 u3 word", 32'(vword[3]), 32'(wc));
    chk("R4 u3 valid cycle", 32'(vn[3]), 32'd87);
    chk("R4 clock-only u0 no valid", 32'(vcnt[0]), 32'd0);
    for (int i = 27; i <= 30; i++) chk("R5 gap silent", 32'(enlog[0][i]), 32'(EN_NONE));
    chk("R5 u1 first strobe", 32'(sfirst[1]), 32'd31);
    chk("R5 u2 first strobe", 32'(sfirst[2]), 32'd61);
    for (int d = 0; d < 4; d++) chk("R9 idle after last gap", 32'(enlog[d][95]), 32'(EN_NONE));
  endtask

  task automatic t_backpressure();
    logic [W-1:0] wd = 26'h3000001, we = 26'h0F0F0F0;
    load(0, wd);
    @(negedge clk) begin tx_valid[0] = 1'b1; tx_word_v[0] = we; end
    repeat (3) @(negedge clk) chk("R7 refuse while holding", 32'(tx_ready[0]), 32'd0);
    tx_valid[0] = 1'b0;
    launch_round();
    observe_to(100);
    chk("R7 ready in first tx cycle", 32'(rdy0log[1]), 32'd1);
    chk("R7 held word delivered", 32'(vword[1]), 32'(wd));
    chk("R7 single delivery", 32'(vcnt[1]), 32'd1);
  endtask

  task automatic t_no_word();
    launch_round();
    observe_to(100);
    for (int d = 0; d < 4; d++) begin
      chk("R8 no strobes", 32'(scnt[d]), 32'd0);
      chk("R8 no valid", 32'(vcnt[d]), 32'd0);
    end
    chk("R8 sender leaves bits", 32'(enlog[0][27]), 32'(EN_NONE));
    chk("R8 sender moves to phase1", 32'(enlog[0][31]), 32'(EN_RXC));
    chk("R8 receiver stalls", 32'(enlog[1][31]), 32'(EN_RXD));
  endtask

  task automatic t_restart();
    logic [W-1:0] wf = 26'h0000155, wg = 26'h2AAAAAB;
    load(0, wf);
    launch_round();
    observe_to(45);
    load(0, wg);
    launch_round();
    observe_to(40);
    chk("R6 u0 back to phase0", 32'(enlog[0][1]), 32'(EN_TX));
    chk("R6 u1 back to phase0", 32'(enlog[1][1]), 32'(EN_RXD));
    chk("R6 word after restart", 32'(vword[1]), 32'(wg));
    chk("R6 valid cycle after restart", 32'(vn[1]), 32'd27);
  endtask

  task automatic t_spread_strobes();
    logic [W-1:0] wd = 26'h2C3A5F1;
    inj = 1'b1;
    launch_round();
    for (int k = 0; k < W; k++) begin
      inj_strobe = 1'b1;
      inj_data = wd[W-1-k];
      @(negedge clk); n++; record();
      inj_strobe = 1'b0;
      @(negedge clk); n++; record();
    end
    chk("R10 spread strobes count", 32'(vcnt[1]), 32'd1);
    chk("R10 spread strobes word", 32'(vword[1]), 32'(wd));
    chk("R10 spread strobes cycle", 32'(vn[1]), 32'd52);
    chk("R4 clock-only u2 no valid", 32'(vcnt[2]), 32'd0);
    inj = 1'b0;
    observe_to(100);
  endtask

  initial begin
    clear_log();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_round();
    t_backpressure();
    t_no_word();
    t_restart();
    t_spread_strobes();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule